// File: doc/BRIEF.md
# Tagged Index Register Address Modifier

This block keeps a small file of index registers and uses it to form effective addresses. An instruction presents a 15-bit address and a 3-bit tag. The block captures both in a tag register. From the following cycle on, it outputs the address minus the index value that the tag chooses, modulo 2^15. The subtraction is done by adding the two's complement of the index value.

A 1-bit mode register chooses how the tag is read, and the program sets it.

- **Single-select mode:** the tag value names one of registers 1 to 7.
- **Multiple-tag mode:** each tag bit enables one of registers 1, 2 and 4, and the enabled contents are ORed together before the subtraction. This mode keeps code written for machines with three index registers working.

A write port can either load the registers or add a signed change to them. Every write passes through a per-register index adder. Writes decode their tag with the same mode rule as reads.

Top module: `idx_addr_mod`

## Requirements
- R1: After reset the mode register is single-select (0), every index register holds zero and `ea_valid` is low.
- R2: The effective address equals the captured address minus the chosen index value, modulo 2^15, so an index value larger than the address wraps.
- R3: A captured tag of zero selects no register, and `ea` equals the captured address in both modes.
- R4: In single-select mode (mode 0) a tag value n from 1 to 7 uses register n alone as the index value.
- R5: In multiple-tag mode (mode 1), tag bit 0 enables register 1, bit 1 enables register 2 and bit 2 enables register 4. The index value is the bitwise OR of every enabled register, and registers 3, 5, 6 and 7 are never used.
- R6: When `mode_wr_en` is high at a clock edge, the mode register takes `mode_wr_val` (1 = multiple-tag). Otherwise it keeps its value.
- R7: When `inst_valid` is high at a clock edge, the address and tag are captured. `ea_valid` is high for exactly the following cycle. `ea` keeps reflecting the captured address and tag until the next capture, using the current register contents.
- R8: A write with `xr_wr_add` = 0 loads `xr_wr_data` into the register or registers that `xr_wr_tag` selects under the current mode. A write with tag zero changes no register.
- R9: In multiple-tag mode, one write updates every register whose tag bit is set (1, 2 and/or 4).
- R10: A write with `xr_wr_add` = 1 adds `xr_wr_data` to each selected register, modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Load the tag-mode register |
| mode_wr_val | input | 1 | New mode: 0 single-select, 1 multiple-tag |
| xr_wr_en | input | 1 | Index register write strobe |
| xr_wr_add | input | 1 | 0 load data, 1 add data to the register |
| xr_wr_tag | input | 3 | Tag that selects the written register(s) |
| xr_wr_data | input | 15 | Write data or increment |
| inst_valid | input | 1 | Capture address and tag |
| inst_addr | input | 15 | Instruction address field |
| inst_tag | input | 3 | Instruction tag field |
| ea_valid | output | 1 | High the cycle after a capture |
| ea | output | 15 | Effective address |

## Verification
The hardest case to reach is multiple-tag mode with two or three enabled registers whose contents differ. In that case an OR is easy to tell apart from a sum or from a single register. Reaching it takes a mode change, a multiple-tag write and then a read, in that order. The bench sets this up with directed sequences that load registers 1, 2 and 4 with overlapping bit patterns and read them back in both modes. Seeded random traffic then mixes mode switches, loads and adds that land in the same cycle as captures.

// File: rtl/idxm_pkg.sv
package idxm_pkg;
   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_MULTI  = 1'b1
   } tag_mode_e;

   typedef enum logic {
      OP_LOAD = 1'b0,
      OP_ADD  = 1'b1
   } wr_op_e;
endpackage

// File: rtl/idxm_adder.sv
module idxm_adder #(
   parameter int W = 15
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   logic [W-1:0] b_eff;
   logic [W-1:0] cin;

   assign b_eff = sub ? ~b : b;
   assign cin   = W'(sub);
   assign y     = a + b_eff + cin;
endmodule

// File: rtl/idxm_decode.sv
module idxm_decode #(
   parameter int TAG_W  = 3,
   parameter int NUM_XR = 7
) (
   input  logic [TAG_W-1:0] tag,
   input  logic             multi,
   output logic [NUM_XR:1]  mask
);
   for (genvar i = 1; i <= NUM_XR; i++) begin : g_sel
      localparam bit IS_POW2 = ((i & (i - 1)) == 0);
      if (IS_POW2) begin : g_bit
         localparam int BIT_POS = $clog2(i);
         assign mask[i] = multi ? tag[BIT_POS] : (tag == TAG_W'(i));
      end else begin : g_plain
         assign mask[i] = !multi && (tag == TAG_W'(i));
      end
   end
endmodule

// File: rtl/idxm_regfile.sv
module idxm_regfile #(
   parameter int ADDR_W = 15,
   parameter int NUM_XR = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_add,
   input  logic [NUM_XR:1]          wr_mask,
   input  logic [ADDR_W-1:0]        wr_data,
   output logic [NUM_XR*ADDR_W-1:0] xr_flat
);
   for (genvar i = 1; i <= NUM_XR; i++) begin : g_xr
      logic [ADDR_W-1:0] xr_q;
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] nxt;

      assign base = wr_add ? xr_q : '0;

      idxm_adder #(.W(ADDR_W)) u_xad (
         .a   (base),
         .b   (wr_data),
         .sub (1'b0),
         .y   (nxt)
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                  xr_q <= '0;
         else if (wr_en && wr_mask[i]) xr_q <= nxt;
      end

      assign xr_flat[(i-1)*ADDR_W +: ADDR_W] = xr_q;
   end
endmodule

// File: rtl/idxm_select.sv
module idxm_select #(
   parameter int ADDR_W = 15,
   parameter int NUM_XR = 7
) (
   input  logic [NUM_XR*ADDR_W-1:0] xr_flat,
   input  logic [NUM_XR:1]          mask,
   output logic [ADDR_W-1:0]        idx_val
);
   always_comb begin
      idx_val = '0;
      for (int i = 1; i <= NUM_XR; i++) begin
         if (mask[i]) idx_val = idx_val | xr_flat[(i-1)*ADDR_W +: ADDR_W];
      end
   end
endmodule

// File: rtl/idx_addr_mod.sv
module idx_addr_mod #(
   parameter int ADDR_W = 15,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_en,
   input  logic              mode_wr_val,
   input  logic              xr_wr_en,
   input  logic              xr_wr_add,
   input  logic [TAG_W-1:0]  xr_wr_tag,
   input  logic [ADDR_W-1:0] xr_wr_data,
   input  logic              inst_valid,
   input  logic [ADDR_W-1:0] inst_addr,
   input  logic [TAG_W-1:0]  inst_tag,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea
);
   import idxm_pkg::*;

   localparam int NUM_XR = (1 << TAG_W) - 1;

   if (ADDR_W < 2)              $error("idx_addr_mod: ADDR_W must be at least 2");
   if (TAG_W < 1 || TAG_W > 5)  $error("idx_addr_mod: TAG_W must be 1..5");

   tag_mode_e                 mode_q;
   wr_op_e                    wr_op;
   logic [ADDR_W-1:0]         addr_q;
   logic [TAG_W-1:0]          tag_q;
   logic                      ev_q;
   logic [NUM_XR:1]           wr_mask;
   logic [NUM_XR:1]           rd_mask;
   logic [NUM_XR*ADDR_W-1:0]  xr_flat;
   logic [ADDR_W-1:0]         idx_val;

   assign wr_op = wr_op_e'(xr_wr_add);

   always_ff @(posedge clk) begin
      if (!rst_n)          mode_q <= MODE_SINGLE;
      else if (mode_wr_en) mode_q <= tag_mode_e'(mode_wr_val);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         tag_q  <= '0;
         ev_q   <= 1'b0;
      end else begin
         ev_q <= inst_valid;
         if (inst_valid) begin
            addr_q <= inst_addr;
            tag_q  <= inst_tag;
         end
      end
   end

   idxm_decode #(.TAG_W(TAG_W), .NUM_XR(NUM_XR)) u_wr_dec (
      .tag   (xr_wr_tag),
      .multi (mode_q == MODE_MULTI),
      .mask  (wr_mask)
   );

   idxm_decode #(.TAG_W(TAG_W), .NUM_XR(NUM_XR)) u_rd_dec (
      .tag   (tag_q),
      .multi (mode_q == MODE_MULTI),
      .mask  (rd_mask)
   );

   idxm_regfile #(.ADDR_W(ADDR_W), .NUM_XR(NUM_XR)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (xr_wr_en),
      .wr_add  (wr_op == OP_ADD),
      .wr_mask (wr_mask),
      .wr_data (xr_wr_data),
      .xr_flat (xr_flat)
   );

   idxm_select #(.ADDR_W(ADDR_W), .NUM_XR(NUM_XR)) u_sel (
      .xr_flat (xr_flat),
      .mask    (rd_mask),
      .idx_val (idx_val)
   );

   idxm_adder #(.W(ADDR_W)) u_ea_add (
      .a   (addr_q),
      .b   (idx_val),
      .sub (1'b1),
      .y   (ea)
   );

   assign ea_valid = ev_q;
endmodule

// File: rtl/idxm_chk.sv
module idxm_chk #(
   parameter int ADDR_W = 15,
   parameter int TAG_W  = 3
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 mode_wr_en,
   input logic                                 xr_wr_en,
   input logic [TAG_W-1:0]                     xr_wr_tag,
   input logic                                 inst_valid,
   input logic                                 ea_valid,
   input logic [ADDR_W-1:0]                    ea,
   input logic                                 mode_q,
   input logic [ADDR_W-1:0]                    addr_q,
   input logic [TAG_W-1:0]                     tag_q,
   input logic [(1<<TAG_W)-1:1]                rd_mask,
   input logic [ADDR_W-1:0]                    idx_val,
   input logic [((1<<TAG_W)-1)*ADDR_W-1:0]     xr_flat
);
   localparam int NUM_XR = (1 << TAG_W) - 1;

   logic [NUM_XR:1] pow2_mask;
   always_comb begin
      pow2_mask = '0;
      for (int i = 1; i <= NUM_XR; i++) begin
         if ((i & (i - 1)) == 0) pow2_mask[i] = 1'b1;
      end
   end

   assert_ea_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> (ADDR_W'(ea + idx_val) == addr_q));

   assert_tag_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_q == '0) |-> (ea == addr_q));

   assert_single_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> $onehot0(rd_mask));

   assert_multi_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> ((rd_mask & ~pow2_mask) == '0));

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr_en |=> $stable(mode_q));

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid |=> ea_valid);

   assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !inst_valid |=> !ea_valid);

   assert_tag0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xr_wr_en && xr_wr_tag == '0) |=> $stable(xr_flat));
endmodule

bind idx_addr_mod idxm_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_wr_en (mode_wr_en),
   .xr_wr_en   (xr_wr_en),
   .xr_wr_tag  (xr_wr_tag),
   .inst_valid (inst_valid),
   .ea_valid   (ea_valid),
   .ea         (ea),
   .mode_q     (mode_q),
   .addr_q     (addr_q),
   .tag_q      (tag_q),
   .rd_mask    (rd_mask),
   .idx_val    (idx_val),
   .xr_flat    (xr_flat)
);

// File: tb/idx_addr_mod_tb_top.sv
`timescale 1ns/1ps
module idx_addr_mod_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_wr_en, mode_wr_val;
   logic        xr_wr_en, xr_wr_add;
   logic [2:0]  xr_wr_tag;
   logic [14:0] xr_wr_data;
   logic        inst_valid;
   logic [14:0] inst_addr;
   logic [2:0]  inst_tag;
   logic        ea_valid;
   logic [14:0] ea;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [14:0] xr_m [1:7];
   logic        mode_m;
   logic [14:0] addr_m;
   logic [2:0]  tag_m;
   logic        ev_m;

   always #4 clk = ~clk;

   idx_addr_mod dut_i (
      .clk(clk), .rst_n(rst_n),
      .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
      .xr_wr_en(xr_wr_en), .xr_wr_add(xr_wr_add),
      .xr_wr_tag(xr_wr_tag), .xr_wr_data(xr_wr_data),
      .inst_valid(inst_valid), .inst_addr(inst_addr), .inst_tag(inst_tag),
      .ea_valid(ea_valid), .ea(ea)
   );

   function automatic bit sel_m(int i, logic [2:0] tag, logic mode);
      if (mode) return ((i == 1) && tag[0]) || ((i == 2) && tag[1]) || ((i == 4) && tag[2]);
      return (tag == 3'(i));
   endfunction

   function automatic logic [14:0] exp_ea();
      logic [14:0] v = '0;
      for (int i = 1; i <= 7; i++) if (sel_m(i, tag_m, mode_m)) v |= xr_m[i];
      return addr_m - v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit me, input bit mv, input bit we, input bit wa,
                       input logic [2:0] wt, input logic [14:0] wd,
                       input bit iv, input logic [14:0] ia, input logic [2:0] it,
                       input string lbl);
      string req;
      mode_wr_en = me; mode_wr_val = mv;
      xr_wr_en = we; xr_wr_add = wa; xr_wr_tag = wt; xr_wr_data = wd;
      inst_valid = iv; inst_addr = ia; inst_tag = it;
      @(posedge clk);
      #2;
      // model: writes decode with the mode before this edge
      if (we) begin
         for (int i = 1; i <= 7; i++)
            if (sel_m(i, wt, mode_m)) xr_m[i] = wa ? xr_m[i] + wd : wd;
      end
      if (me) mode_m = mv;
      ev_m = iv;
      if (iv) begin addr_m = ia; tag_m = it; end
      chk("R7 ea_valid", {31'd0, ea_valid}, {31'd0, ev_m});
      if (lbl != "") req = lbl;
      else if (tag_m == 0) req = "R3";
      else if (mode_m) req = "R5/R2";
      else req = "R4/R2";
      chk(req, {17'd0, ea}, {17'd0, exp_ea()});
   endtask

   task automatic idle(string lbl);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, lbl);
   endtask

   task automatic rd(logic [14:0] a, logic [2:0] t, string lbl);
      step(0, 0, 0, 0, 0, 0, 1, a, t, lbl);
   endtask

   task automatic wr(bit add, logic [2:0] t, logic [14:0] d, string lbl);
      step(0, 0, 1, add, t, d, 0, 0, 0, lbl);
   endtask

   task automatic setmode(bit m, string lbl);
      step(1, m, 0, 0, 0, 0, 0, 0, 0, lbl);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 1; i <= 7; i++) xr_m[i] = '0;
      mode_m = 0; addr_m = 0; tag_m = 0; ev_m = 0;
      rst_n = 0;
      mode_wr_en = 0; mode_wr_val = 0; xr_wr_en = 0; xr_wr_add = 0;
      xr_wr_tag = 0; xr_wr_data = 0; inst_valid = 0; inst_addr = 0; inst_tag = 0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 ea_valid after reset", {31'd0, ea_valid}, 32'd0);
      rst_n = 1;
      // R1: every register reads back as zero in single mode
      for (int t = 1; t <= 7; t++) rd(15'd100, 3'(t), "R1");
      // R8: loads in single mode, distinct values
      wr(0, 1, 15'h0011, "R8"); wr(0, 2, 15'h0102, "R8"); wr(0, 3, 15'h0044, "R8");
      wr(0, 4, 15'h1001, "R8"); wr(0, 5, 15'h0005, "R8"); wr(0, 6, 15'h0600, "R8");
      wr(0, 7, 15'h7000, "R8");
      for (int t = 1; t <= 7; t++) rd(15'h7fff, 3'(t), "R4");
      // R8: tag-zero write changes nothing
      wr(0, 0, 15'h2222, "R8");
      for (int t = 1; t <= 7; t++) rd(15'h7fff, 3'(t), "R8");
      // R3: tag zero passes address in single mode
      rd(15'h1234, 0, "R3");
      // R2: wrap when index exceeds address (5 - 0x0044)
      rd(15'd5, 3, "R2");
      // R7: output held while idle
      idle("R7"); idle("R7");
      // R6: switch to multiple-tag mode
      setmode(1, "R6");
      rd(15'h7fff, 3, "R5 tag3 = xr1|xr2");
      rd(15'h7fff, 7, "R5 tag7 = xr1|xr2|xr4");
      rd(15'h7fff, 5, "R5 tag5 = xr1|xr4");
      rd(15'h1234, 0, "R3 multi");
      // R9: multi write updates registers 1 and 4
      wr(0, 5, 15'h0300, "R9");
      setmode(0, "R6");
      for (int t = 1; t <= 7; t++) rd(15'h4000, 3'(t), "R9");
      // R10: add with wrap
      wr(1, 7, 15'h1001, "R10");
      rd(15'h0, 7, "R10");
      setmode(1, "R6"); wr(1, 6, 15'h0001, "R10");
      setmode(0, "R6");
      rd(15'h0, 2, "R10"); rd(15'h0, 4, "R10"); rd(15'h0, 6, "R10");
      // mode write ignored when enable low
      step(0, 1, 0, 0, 0, 0, 1, 15'h7fff, 3, "R6");
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         bit me, mv, we, wa, iv;
         logic [2:0] wt, it;
         logic [14:0] wd, ia;
         me = ($urandom % 16) == 0; mv = $urandom; we = ($urandom % 3) == 0;
         wa = $urandom; wt = 3'($urandom); wd = 15'($urandom);
         iv = ($urandom % 2) == 0; ia = 15'($urandom); it = 3'($urandom);
         step(me, mv, we, wa, wt, wd, iv, ia, it, "");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule